// File: doc/BRIEF.md
# Byte-Addressed SRAM Controller with Posted Write

This block sits between a CPU-side request port and an on-chip 32-bit wide storage array. It accepts byte, halfword and word reads and writes. Each access goes to the naturally aligned location that contains the given address, and byte lanes are placed little-endian.

Every write lands first in a one-entry posted-write buffer, so writes can be issued on consecutive cycles without stalling. The buffered write is copied into the array only when a later write is accepted, and the new write then takes its place in the buffer. Reads look at the buffer and at the array together, so they always see the latest data. A reset drops the buffered write without copying it into the array. Software that needs a write to survive a reset issues it twice, or follows it with any other write.

Top module: `sram_pwb`

## Requirements
- R1: The size code `req_size_i` selects 8-bit (00), 16-bit (01) or 32-bit (10) access; code 11 behaves as a 32-bit access.
- R2: A halfword access ignores address bit 0 and a word access ignores address bits 1:0, so the access hits the naturally aligned location containing the address.
- R3: Lanes are little-endian: the byte at word offset k is held in bits 8k+7:8k of the word. A write stores only the low 8 or 16 bits of `req_wdata_i` for byte or halfword size.
- R4: A read accepted in cycle t raises `rsp_valid_o` for exactly cycle t+1, with the selected lanes shifted down to bit 0 and zero-extended in `rsp_rdata_o`. No other cycle shows `rsp_valid_o` high.
- R5: A write is taken in every cycle in which it is offered, so writes can arrive on consecutive cycles.
- R6: A read returns the most recent data, including a write still held in the buffer. Lanes the buffered write did not enable come from the array.
- R7: The buffered write is committed to the array only when the next write is accepted, and that new write then occupies the buffer.
- R8: An active-low reset empties the buffer without committing it, so the array keeps its value from before the last write.
- R9: A write that is repeated, or that is followed by any other write, is preserved in the array across a reset.
- R10: While reset is asserted, `rsp_valid_o` is low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Access size code (see R1) |
| req_addr_i | input | AW | Byte address |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data, right-aligned and zero-extended |

## Verification
The array is first filled with word writes. After that, every byte address is swept at each size. Each write is followed at once by a read of the same size, which is served from the buffer. A whole-word read then follows, and it mixes buffer lanes with array lanes. Together these separate wrong lane placement, wrong alignment and missing zero-extension from a merge that takes the wrong lanes. Reset cases tell apart a single write, which must be lost, from a repeated write or a write followed by a dummy write, both of which must survive.

// File: rtl/sram_pwb_pkg.sv
package sram_pwb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  localparam int unsigned LANES = 4;

  typedef struct packed {
    logic [LANES-1:0]   be;
    logic [8*LANES-1:0] data;
  } lane_word_t;
endpackage

// File: rtl/sram_pwb_wsteer.sv
module sram_pwb_wsteer
  import sram_pwb_pkg::*;
(
  input  logic [1:0]  size_i,
  input  logic [1:0]  off_i,
  input  logic [31:0] wdata_i,
  output lane_word_t  lanes_o
);
  always_comb begin
    unique case (size_e'(size_i))
      SZ_BYTE: begin
        lanes_o.be   = 4'b0001 << off_i;
        lanes_o.data = {4{wdata_i[7:0]}};
      end
      SZ_HALF: begin
        lanes_o.be   = off_i[1] ? 4'b1100 : 4'b0011;
        lanes_o.data = {2{wdata_i[15:0]}};
      end
      default: begin
        lanes_o.be   = 4'b1111;
        lanes_o.data = wdata_i;
      end
    endcase
  end
endmodule

// File: rtl/sram_pwb_rsteer.sv
module sram_pwb_rsteer
  import sram_pwb_pkg::*;
(
  input  logic [1:0]  size_i,
  input  logic [1:0]  off_i,
  input  logic [31:0] word_i,
  output logic [31:0] rdata_o
);
  logic [31:0] shifted;

  always_comb begin
    unique case (size_e'(size_i))
      SZ_BYTE: begin
        shifted = word_i >> {off_i, 3'b000};
        rdata_o = {24'd0, shifted[7:0]};
      end
      SZ_HALF: begin
        shifted = word_i >> {off_i[1], 4'b0000};
        rdata_o = {16'd0, shifted[15:0]};
      end
      default: begin
        shifted = word_i;
        rdata_o = word_i;
      end
    endcase
  end
endmodule

// File: rtl/sram_pwb_buf.sv
module sram_pwb_buf
  import sram_pwb_pkg::*;
#(
  parameter int unsigned WW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [WW-1:0] word_i,
  input  lane_word_t    lanes_i,
  output logic          valid_o,
  output logic [WW-1:0] word_o,
  output lane_word_t    lanes_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word_o  <= '0;
      lanes_o <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      word_o  <= word_i;
      lanes_o <= lanes_i;
    end
  end
endmodule

// File: rtl/sram_pwb_array.sv
module sram_pwb_array
  import sram_pwb_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned WW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [WW-1:0] waddr_i,
  input  lane_word_t    wlanes_i,
  input  logic          re_i,
  input  logic [WW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem [DEPTH];

  // storage is not reset: contents survive a warm reset
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int i = 0; i < LANES; i++) begin
        if (wlanes_i.be[i]) mem[waddr_i][8*i +: 8] <= wlanes_i.data[8*i +: 8];
      end
    end
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/sram_pwb.sv
module sram_pwb
  import sram_pwb_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned WW   = $clog2(DEPTH),
  localparam int unsigned AW   = WW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_we_i,
  input  logic [1:0]    req_size_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [31:0]   req_wdata_i,
  output logic          rsp_valid_o,
  output logic [31:0]   rsp_rdata_o
);
  logic          wr_acc, rd_acc;
  lane_word_t    new_lanes;
  logic          pb_valid;
  logic [WW-1:0] pb_word;
  lane_word_t    pb_lanes;
  logic [31:0]   arr_rdata;
  logic [31:0]   merged;
  logic          rd_q;
  logic [WW-1:0] rd_word_q;
  logic [1:0]    rd_size_q, rd_off_q;
  logic          hit;

  assign wr_acc = req_valid_i &  req_we_i;
  assign rd_acc = req_valid_i & ~req_we_i;

  sram_pwb_wsteer u_wsteer (
    .size_i (req_size_i),
    .off_i  (req_addr_i[1:0]),
    .wdata_i(req_wdata_i),
    .lanes_o(new_lanes)
  );

  sram_pwb_buf #(.WW(WW)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wr_acc),
    .word_i (req_addr_i[AW-1:2]),
    .lanes_i(new_lanes),
    .valid_o(pb_valid),
    .word_o (pb_word),
    .lanes_o(pb_lanes)
  );

  // commit of the old entry coincides with the next write; reads never collide
  sram_pwb_array #(.DEPTH(DEPTH)) u_array (
    .clk_i   (clk_i),
    .we_i    (wr_acc & pb_valid),
    .waddr_i (pb_word),
    .wlanes_i(pb_lanes),
    .re_i    (rd_acc),
    .raddr_i (req_addr_i[AW-1:2]),
    .rdata_o (arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q      <= 1'b0;
      rd_word_q <= '0;
      rd_size_q <= '0;
      rd_off_q  <= '0;
    end else begin
      rd_q <= rd_acc;
      if (rd_acc) begin
        rd_word_q <= req_addr_i[AW-1:2];
        rd_size_q <= req_size_i;
        rd_off_q  <= req_addr_i[1:0];
      end
    end
  end

  // buffer cannot change between read acceptance and response: no write in between
  assign hit = pb_valid && (pb_word == rd_word_q);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[8*g +: 8] = (hit && pb_lanes.be[g]) ? pb_lanes.data[8*g +: 8]
                                                      : arr_rdata[8*g +: 8];
  end

  sram_pwb_rsteer u_rsteer (
    .size_i (rd_size_q),
    .off_i  (rd_off_q),
    .word_i (merged),
    .rdata_o(rsp_rdata_o)
  );

  assign rsp_valid_o = rd_q;
endmodule

// File: rtl/sram_pwb_chk.sv
module sram_pwb_chk
  import sram_pwb_pkg::*;
#(
  parameter int unsigned AW = 10,
  localparam int unsigned WW = AW - 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_we_i,
  input logic [1:0]    req_size_i,
  input logic [AW-1:0] req_addr_i,
  input logic          rsp_valid_o,
  input logic [31:0]   rsp_rdata_o,
  input logic          pb_valid_i,
  input logic [WW-1:0] pb_word_i,
  input lane_word_t    pb_lanes_i
);
  // R4
  rd_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_we_i) |=> rsp_valid_o);

  // R4
  no_spur_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_we_i) |=> !rsp_valid_o);

  // R4
  byte_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_we_i && req_size_i == 2'b00) |=> (rsp_rdata_o[31:8] == 24'd0));

  // R4
  half_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_we_i && req_size_i == 2'b01) |=> (rsp_rdata_o[31:16] == 16'd0));

  // R5
  wr_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_we_i) |=> (pb_valid_i && pb_word_i == $past(req_addr_i[AW-1:2])));

  // R7
  buf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_we_i) |=> ($stable(pb_lanes_i) && $stable(pb_word_i) && $stable(pb_valid_i)));

  // R10
  rst_empty_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!pb_valid_i && !rsp_valid_o));
endmodule

bind sram_pwb sram_pwb_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_we_i   (req_we_i),
  .req_size_i (req_size_i),
  .req_addr_i (req_addr_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_rdata_o(rsp_rdata_o),
  .pb_valid_i (pb_valid),
  .pb_word_i  (pb_word),
  .pb_lanes_i (pb_lanes)
);

// File: tb/sram_pwb_bench.sv
module sram_pwb_bench;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH) + 2;
  localparam int NB    = 4 * DEPTH;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_we_i = 1'b0;
  logic [1:0]    req_size_i = 2'b00;
  logic [AW-1:0] req_addr_i = '0;
  logic [31:0]   req_wdata_i = '0;
  logic          rsp_valid_o;
  logic [31:0]   rsp_rdata_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] lat_m [NB];
  logic [7:0] com_m [NB];
  logic [7:0] pend_d [4];
  int         pend_base;
  int         pend_n;
  logic       pend_v = 1'b0;

  always #10 clk_i = ~clk_i;

  sram_pwb #(.DEPTH(DEPTH)) u_sram_pwb (.*);

  function automatic int sz_bytes(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  function automatic int base_of(input int a, input logic [1:0] s);
    return a - (a % sz_bytes(s));
  endfunction

  function automatic logic [31:0] exp_rd(input int a, input logic [1:0] s);
    logic [31:0] w = '0;
    int b = base_of(a, s);
    for (int k = 0; k < sz_bytes(s); k++) w[8*k +: 8] = lat_m[b + k];
    return w;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic do_wr(input int a, input logic [1:0] s, input logic [31:0] d);
    int b = base_of(a, s);
    if (pend_v) for (int k = 0; k < pend_n; k++) com_m[pend_base + k] = pend_d[k];
    pend_v = 1'b1; pend_base = b; pend_n = sz_bytes(s);
    for (int k = 0; k < sz_bytes(s); k++) begin
      lat_m[b + k] = d[8*k +: 8];
      pend_d[k]    = d[8*k +: 8];
    end
    @(negedge clk_i);
    req_valid_i = 1'b1; req_we_i = 1'b1; req_size_i = s;
    req_addr_i = AW'(a); req_wdata_i = d;
    @(posedge clk_i); #1;
    req_valid_i = 1'b0;
  endtask

  task automatic do_rd(input int a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_we_i = 1'b0; req_size_i = s; req_addr_i = AW'(a);
    @(posedge clk_i); #1;
    req_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R4 rsp_valid", {31'd0, rsp_valid_o}, 32'd1);
    d = rsp_rdata_o;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R10 rsp_valid in reset", {31'd0, rsp_valid_o}, 32'd0);
    rst_ni = 1'b1;
    pend_v = 1'b0;
    for (int i = 0; i < NB; i++) lat_m[i] = com_m[i];
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL R5 watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    @(negedge clk_i);
    chk("R10 reset rsp_valid", {31'd0, rsp_valid_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // fill array, back-to-back writes (R5)
    for (int w = 0; w < DEPTH; w++) do_wr(4 * w, 2'b10, 32'h1111_0000 + w * 32'h0101);
    do_wr(0, 2'b10, 32'h1111_0000);
    @(negedge clk_i);
    chk("R4 no rsp after write", {31'd0, rsp_valid_o}, 32'd0);
    for (int w = 0; w < DEPTH; w++) begin
      do_rd(4 * w, 2'b10, r);
      chk("R5 back-to-back fill", r, exp_rd(4 * w, 2'b10));
    end

    // sweep sizes and every byte address (R1 R2 R3 R6 R7)
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < NB; a++) begin
        logic [31:0] d = 32'hA500_0000 ^ (a * 32'h0103_0507) ^ (s << 20);
        do_wr(a, 2'(s), d);
        do_rd(a, 2'(s), r);
        chk(s == 3 ? "R1 rsvd size as word" : "R3 R2 same-size readback", r, exp_rd(a, 2'(s)));
        do_rd(a, 2'b10, r);
        chk("R6 merged word read", r, exp_rd(a, 2'b10));
        do_rd((a + 5) % NB, 2'b00, r);
        chk("R7 other byte", r, exp_rd((a + 5) % NB, 2'b00));
      end
    end

    // single write is lost on reset (R8)
    do_wr(8, 2'b10, 32'hCAFE_0001);
    do_wr(8, 2'b10, 32'hCAFE_0001);
    do_wr(8, 2'b10, 32'hDEAD_BEEF);
    do_rd(8, 2'b10, r);
    chk("R6 pending visible", r, 32'hDEAD_BEEF);
    do_reset();
    do_rd(8, 2'b10, r);
    chk("R8 pending discarded", r, 32'hCAFE_0001);

    // repeated write survives (R9)
    do_wr(12, 2'b01, 32'h0000_7A7A);
    do_wr(12, 2'b01, 32'h0000_7A7A);
    do_reset();
    do_rd(12, 2'b01, r);
    chk("R9 repeated write kept", r, 32'h0000_7A7A);

    // dummy write commits the earlier one (R9), dummy itself lost (R8)
    do_wr(21, 2'b00, 32'hFFFF_FF3C);
    do_wr(40, 2'b00, 32'h0000_0099);
    do_reset();
    do_rd(21, 2'b00, r);
    chk("R9 dummy write commit", r, 32'h0000_003C);
    do_rd(40, 2'b00, r);
    chk("R8 dummy discarded", r, exp_rd(40, 2'b00));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule